// File: doc/BRIEF.md
# Dual Processor Interrupt Timer

This block derives periodic interrupt requests for two processors from one shared slow tick enable, nominally around 5 kHz. Each processor gets a private 4-bit counter and a one-cycle acknowledge strobe.

The first channel works as a one-shot. While armed, its counter advances on each tick. When the counter value has both of its top two bits set, the channel raises a level interrupt and disarms itself. It then waits, with the counter frozen and the interrupt held high, until its processor acknowledges.

The second channel is a free-running counter whose most significant bit drives the interrupt line directly. The line therefore toggles on its own as the count wraps, and an acknowledge clears the counter to restart the period. A presence input parks the second channel at zero when that processor is not fitted.

Top module: `dual_irq_timer`

## Requirements
- R1: Counters advance only in cycles where `tick` is 1; a cycle without `tick` or an acknowledge changes no counter and no interrupt output.
- R2: Starting armed from a zero count, `irq_a` rises in the cycle after the twelfth tick, when the first counter reaches 12 (bits 3 and 2 both 1), and the channel disarms at that point.
- R3: While disarmed, further ticks leave the first counter unchanged and keep `irq_a` at 1.
- R4: A pulse on `ack_a` drops `irq_a` in the next cycle, clears the first counter to zero and re-arms it, so exactly twelve more ticks bring `irq_a` back.
- R5: With `b_present` at 1, `irq_b` equals bit 3 of the second counter: it rises after the 8th tick and falls after the 16th as the count wraps to zero.
- R6: A pulse on `ack_b` drops `irq_b` and clears the second counter to zero, so `irq_b` next rises after 8 further ticks.
- R7: After synchronous reset both counters are zero, the first channel is armed, and `irq_a` and `irq_b` are 0.
- R8: When an acknowledge and a tick fall in the same cycle, the acknowledge wins and the counter of that channel ends at zero.
- R9: While `b_present` is 0, the second counter is held at zero and `irq_b` stays 0; after `b_present` returns to 1, eight ticks are needed for `irq_b` to rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Shared slow tick enable, one cycle wide |
| ack_a | input | 1 | Acknowledge strobe from the first processor |
| ack_b | input | 1 | Acknowledge strobe from the second processor |
| b_present | input | 1 | Second processor fitted; 0 parks its channel |
| irq_a | output | 1 | Level interrupt to the first processor |
| irq_b | output | 1 | Interrupt to the second processor |

## Verification
The bench builds the block with its default parameters: a 4-bit counter width, a fire pattern of 12 for the one-shot channel, and bit 3 as the free-running output. With these values a full free-running wrap takes only sixteen ticks and a one-shot cycle takes twelve. Repeated wraps, disarmed periods, acknowledge collisions with ticks and presence toggling therefore all fit in a few hundred clock cycles, with idle gaps placed between ticks.

// File: rtl/dpit_pkg.sv
package dpit_pkg;
    localparam int DEF_CNT_W = 4;
    localparam logic [DEF_CNT_W-1:0] DEF_FIRE_MASK = 4'b1100;
    localparam int DEF_OUT_BIT = 3;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_FIRED = 1'b1
    } oneshot_st_e;
endpackage

// File: rtl/dpit_oneshot_chan.sv
module dpit_oneshot_chan
    import dpit_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter logic [CNT_W-1:0] FIRE_MASK = DEF_FIRE_MASK
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack,
    output logic irq
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    oneshot_st_e      st;

    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            cnt <= '0;
            st  <= ST_ARMED;
            irq <= 1'b0;
        end else if (tick && st == ST_ARMED) begin
            cnt <= cnt_inc;
            if ((cnt_inc & FIRE_MASK) == FIRE_MASK) begin
                st  <= ST_FIRED;
                irq <= 1'b1;
            end
        end
    end

    // R1: idle cycles change nothing
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ack) |=> ($stable(cnt) && $stable(irq)));
    // R3: disarmed channel holds its count and keeps the request high
    a_r3_disarmed_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FIRED && !ack) |=> (irq && $stable(cnt)));
    // R4, R8: acknowledge drops the request and zeroes the count
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!irq && cnt == '0 && st == ST_ARMED));
    // R2: request is only raised when the pattern is matched
    a_r2_fire_on_pattern: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ((cnt & FIRE_MASK) == FIRE_MASK));
endmodule

// File: rtl/dpit_freerun_chan.sv
module dpit_freerun_chan
    import dpit_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int OUT_BIT = DEF_OUT_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack,
    input  logic present,
    output logic irq
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !present || ack) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign irq = cnt[OUT_BIT];

    // R9: absent processor parks the channel
    a_r9_absent_parked: assert property (@(posedge clk) disable iff (rst)
        !present |=> (cnt == '0 && !irq));
    // R6, R8: acknowledge restarts the period
    a_r6_ack_restart: assert property (@(posedge clk) disable iff (rst)
        ack |=> (cnt == '0 && !irq));
    // R5: full count wraps to zero on the next tick
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        (present && tick && !ack && cnt == '1) |=> (cnt == '0));
    // R1: no tick, no movement
    a_r1_b_idle: assert property (@(posedge clk) disable iff (rst)
        (present && !tick && !ack) |=> $stable(cnt));
endmodule

// File: rtl/dual_irq_timer.sv
module dual_irq_timer
    import dpit_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter logic [CNT_W-1:0] FIRE_MASK = DEF_FIRE_MASK,
    parameter int OUT_BIT = DEF_OUT_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack_a,
    input  logic ack_b,
    input  logic b_present,
    output logic irq_a,
    output logic irq_b
);
    dpit_oneshot_chan #(
        .CNT_W(CNT_W),
        .FIRE_MASK(FIRE_MASK)
    ) u_chan_a (
        .clk(clk),
        .rst(rst),
        .tick(tick),
        .ack(ack_a),
        .irq(irq_a)
    );

    dpit_freerun_chan #(
        .CNT_W(CNT_W),
        .OUT_BIT(OUT_BIT)
    ) u_chan_b (
        .clk(clk),
        .rst(rst),
        .tick(tick),
        .ack(ack_b),
        .present(b_present),
        .irq(irq_b)
    );

    // R7: reset leaves both requests low
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq_a && !irq_b));
endmodule

// File: tb/tb_dual_irq_timer.sv
module tb_dual_irq_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic ack_a = 1'b0;
    logic ack_b = 1'b0;
    logic b_present = 1'b1;
    logic irq_a;
    logic irq_b;

    int total = 0;
    int bad = 0;
    bit reported = 0;

    typedef struct {
        logic  ea;
        logic  eb;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference state, built from the requirements
    int  m_a_cnt = 0;
    bit  m_a_armed = 1;
    bit  m_a_irq = 0;
    int  m_b_cnt = 0;

    always #5 clk = ~clk;

    dual_irq_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .ack_a(ack_a), .ack_b(ack_b),
        .b_present(b_present), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic check(input string tag, input string name, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
        end
    endtask

    task automatic step(input bit t, input bit aa, input bit ab, input bit p, input string tag);
        exp_t e;
        @(negedge clk);
        tick = t; ack_a = aa; ack_b = ab; b_present = p;
        if (aa) begin
            m_a_cnt = 0; m_a_armed = 1; m_a_irq = 0;
        end else if (t && m_a_armed) begin
            m_a_cnt = (m_a_cnt + 1) % 16;
            if (m_a_cnt >= 12) begin
                m_a_armed = 0; m_a_irq = 1;
            end
        end
        if (!p || ab) m_b_cnt = 0;
        else if (t) m_b_cnt = (m_b_cnt + 1) % 16;
        e.ea = m_a_irq;
        e.eb = (m_b_cnt >= 8);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ticks(input int n, input bit p, input string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, p, tag);
            step(0, 0, 0, p, tag);
        end
    endtask

    // monitor: pops one expectation per clock edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(e.tag, "irq_a", irq_a, e.ea);
                check(e.tag, "irq_b", irq_b, e.eb);
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: state right after reset
        check("R7", "irq_a", irq_a, 1'b0);
        check("R7", "irq_b", irq_b, 1'b0);
        // R1, R2: count up to the fire pattern with idle gaps
        ticks(11, 1, "R1");
        step(0, 0, 0, 1, "R1");
        step(1, 0, 0, 1, "R2");
        step(0, 0, 0, 1, "R2");
        // R3: disarmed, ticks keep the request high
        ticks(6, 1, "R3");
        // R4: acknowledge, then twelve more ticks
        step(0, 1, 0, 1, "R4");
        ticks(12, 1, "R4");
        // R5: let the free channel wrap a few times
        ticks(20, 1, "R5");
        // R6: acknowledge the free channel mid-period
        ticks(3, 1, "R6");
        step(0, 0, 1, 1, "R6");
        ticks(9, 1, "R6");
        // R8: acknowledge together with a tick on both channels
        step(0, 1, 0, 1, "R8");
        ticks(5, 1, "R8");
        step(1, 1, 1, 1, "R8");
        ticks(7, 1, "R8");
        ticks(6, 1, "R8");
        // R9: processor absent, channel parked, then resumes
        ticks(10, 0, "R9");
        step(0, 0, 0, 1, "R9");
        ticks(8, 1, "R9");
        ticks(8, 1, "R9");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        report();
    end
endmodule